// File: doc/BRIEF.md
# Read-Priority Write Buffer for a Slow-Write Memory Array

The block sits between a cache controller and a single-port non-volatile array. On that array a write must be held for many cycles, while a read finishes in one. Write requests are parked in a small associative buffer and retired to the array in the background. Incoming reads go ahead of the parked writes. A read whose address is already buffered is answered straight from the buffer. A second write to a buffered address overwrites that entry's data, so it never costs a second array write.

A read that arrives while a retirement is under way abandons that retirement. The entry stays buffered and its array write later starts again from cycle one. If reads hold retirement back until the buffer reaches a high-water mark, the block enters a drain mode. In drain mode it refuses reads and retires writes until occupancy falls below a low-water mark. Requests use valid/ready handshakes. Read responses are a one-cycle pulse with no back-pressure.

The controller is a state machine with five states:

| State | Behaviour |
|---|---|
| `ST_IDLE` | Chooses the next action. |
| `ST_WRITE` | Holds one array write. |
| `ST_RD_ARRAY` | Issues the array read. |
| `ST_RD_RETURN` | Presents the array data. |
| `ST_RD_HIT` | Presents buffered data. |

Transitions:
- IDLE→RD_HIT or IDLE→RD_ARRAY: a read is accepted; it hits or misses the buffer.
- IDLE→WRITE: no read is accepted and an entry is occupied.
- WRITE→RD_HIT or WRITE→RD_ARRAY: the retirement is pre-empted by a read.
- WRITE→IDLE: the write completes, or a new write merged into the entry being retired.
- RD_ARRAY→RD_RETURN, RD_RETURN→IDLE and RD_HIT→IDLE: these are unconditional.

Top module: `nvm_wbuf`

## Requirements
- R1: After reset the buffer is empty: `wr_ready` and `rd_ready` are 1, and `arr_we`, `arr_rd` and `rsp_valid` are 0.
- R2: Every accepted write reaches the array. An array write counts only after `arr_we` has been held high for `WR_LAT` consecutive cycles, with `arr_addr` and `arr_wdata` unchanged throughout.
- R3: A read that misses the buffer raises `arr_rd` for one cycle, on the cycle after acceptance. `rsp_valid` is 1 two cycles after acceptance, with the array data.
- R4: A read that hits a buffered address gives `rsp_valid` one cycle after acceptance, with the newest buffered data, and never raises `arr_rd`.
- R5: A write to an address already buffered replaces that entry's data without taking a new entry. The address then gets exactly one array write, and it carries the latest data.
- R6: When not in drain mode, a read presented during an array write is accepted in that same cycle. The write is dropped (`arr_we` low) and later restarted from its first cycle.
- R7: `arr_we` and `arr_rd` are never high in the same cycle.
- R8: Once occupancy reaches `HI_MARK`, `rd_ready` is 0 from the next cycle and stays 0 until occupancy has dropped below `LO_MARK`.
- R9: `wr_ready` is 0 only when all `DEPTH` entries are occupied and none holds `wr_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write request valid |
| wr_ready | output | 1 | Write request can be taken |
| wr_addr | input | AW | Write line address |
| wr_data | input | DW | Write data |
| rd_valid | input | 1 | Read request valid |
| rd_ready | output | 1 | Read request can be taken |
| rd_addr | input | AW | Read line address |
| rsp_valid | output | 1 | Read data pulse |
| rsp_data | output | DW | Read data |
| arr_we | output | 1 | Array write strobe, held for a whole write |
| arr_rd | output | 1 | Array read strobe |
| arr_addr | output | AW | Array address |
| arr_wdata | output | DW | Array write data |
| arr_rdata | input | DW | Array read data, valid the cycle after `arr_rd` |

## Verification
The bench uses the default parameters: four entries, an eight-cycle write, a high mark of 3 and a low mark of 1. With these values a burst of three writes enters drain mode well before the first retirement ends. Four back-to-back writes also fill the buffer completely while the head entry is still being written, so the full-buffer refusal and the merge exception can both be probed. The eight-cycle write is long enough for a read to arrive partway through a retirement and pre-empt it.

// File: rtl/nvm_wbuf_pkg.sv
package nvm_wbuf_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WRITE,
        ST_RD_ARRAY,
        ST_RD_RETURN,
        ST_RD_HIT
    } wb_state_t;
endpackage

// File: rtl/wbuf_store.sv
module wbuf_store #(
    parameter int DEPTH = 4,
    parameter int AW    = 8,
    parameter int DW    = 16,
    localparam int IW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_fire,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    output logic          wr_ready,
    output logic          wr_hit,
    output logic [IW-1:0] wr_hit_idx,
    input  logic [AW-1:0] rd_addr,
    output logic          rd_hit,
    output logic [DW-1:0] rd_hit_data,
    input  logic          retire_en,
    input  logic [IW-1:0] retire_idx,
    input  logic [IW-1:0] sel_idx,
    output logic [AW-1:0] sel_addr,
    output logic [DW-1:0] sel_data,
    output logic [IW-1:0] head_idx,
    output logic          any_valid,
    output logic [CW-1:0] occupancy
);
    logic [DEPTH-1:0]  vld_q;
    logic [AW-1:0]     addr_q [DEPTH];
    logic [DW-1:0]     data_q [DEPTH];
    logic [DEPTH-1:0]  wr_match;
    logic [DEPTH-1:0]  rd_match;
    logic [IW-1:0]     free_idx;

    genvar g;
    for (g = 0; g < DEPTH; g++) begin : g_match
        assign wr_match[g] = vld_q[g] && (addr_q[g] == wr_addr);
        assign rd_match[g] = vld_q[g] && (addr_q[g] == rd_addr);
    end

    always_comb begin
        wr_hit_idx  = '0;
        rd_hit_data = '0;
        free_idx    = '0;
        head_idx    = '0;
        occupancy   = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (wr_match[i]) wr_hit_idx = IW'(i);
            if (rd_match[i]) rd_hit_data = data_q[i];
            if (!vld_q[i])   free_idx = IW'(i);
            if (vld_q[i])    head_idx = IW'(i);
            occupancy = occupancy + CW'(vld_q[i]);
        end
    end

    assign wr_hit    = |wr_match;
    assign rd_hit    = |rd_match;
    assign any_valid = |vld_q;
    assign wr_ready  = wr_hit || !(&vld_q);
    assign sel_addr  = addr_q[sel_idx];
    assign sel_data  = data_q[sel_idx];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                addr_q[i] <= '0;
                data_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (retire_en && retire_idx == IW'(i)) begin
                    vld_q[i] <= 1'b0;
                end
                if (wr_fire && wr_hit && wr_hit_idx == IW'(i)) begin
                    data_q[i] <= wr_data;
                end else if (wr_fire && !wr_hit && free_idx == IW'(i)) begin
                    vld_q[i]  <= 1'b1;
                    addr_q[i] <= wr_addr;
                    data_q[i] <= wr_data;
                end
            end
        end
    end

    // R9
    full_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ready |-> (occupancy == CW'(DEPTH)));

    // R5
    merge_retire_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(retire_en && wr_fire && wr_hit && wr_hit_idx == retire_idx));
endmodule

// File: rtl/wbuf_ctrl.sv
module wbuf_ctrl
    import nvm_wbuf_pkg::*;
#(
    parameter int DEPTH   = 4,
    parameter int WR_LAT  = 8,
    parameter int HI_MARK = 3,
    parameter int LO_MARK = 1,
    localparam int IW     = $clog2(DEPTH),
    localparam int CW     = $clog2(DEPTH + 1),
    localparam int LW     = $clog2(WR_LAT)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_valid,
    input  logic          rd_hit,
    input  logic          wr_fire,
    input  logic          wr_hit,
    input  logic [IW-1:0] wr_hit_idx,
    input  logic [CW-1:0] occupancy,
    input  logic          any_valid,
    input  logic [IW-1:0] head_idx,
    output logic          rd_ready,
    output logic          rd_fire,
    output logic          arr_we,
    output logic          arr_rd,
    output logic          rsp_valid,
    output logic          rsp_from_buf,
    output logic          retire_en,
    output logic [IW-1:0] act_idx
);
    wb_state_t     state_q, state_d;
    logic [LW-1:0] cnt_q;
    logic [IW-1:0] act_q;
    logic          drain_q;
    logic          merge_act;
    logic          we_live;
    logic          done;

    assign rd_ready  = (state_q == ST_IDLE || state_q == ST_WRITE) && !drain_q;
    assign rd_fire   = rd_valid && rd_ready;
    assign merge_act = (state_q == ST_WRITE) && wr_fire && wr_hit && (wr_hit_idx == act_q);
    assign we_live   = (state_q == ST_WRITE) && !rd_fire && !merge_act;
    assign done      = we_live && (cnt_q == LW'(WR_LAT - 1));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (rd_fire)        state_d = rd_hit ? ST_RD_HIT : ST_RD_ARRAY;
                else if (any_valid) state_d = ST_WRITE;
            end
            ST_WRITE: begin
                if (rd_fire)                state_d = rd_hit ? ST_RD_HIT : ST_RD_ARRAY;
                else if (merge_act || done) state_d = ST_IDLE;
            end
            ST_RD_ARRAY:  state_d = ST_RD_RETURN;
            ST_RD_RETURN: state_d = ST_IDLE;
            ST_RD_HIT:    state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            act_q   <= '0;
            drain_q <= 1'b0;
        end else begin
            state_q <= state_d;
            drain_q <= drain_q ? (occupancy >= CW'(LO_MARK)) : (occupancy >= CW'(HI_MARK));
            if (state_q == ST_IDLE && state_d == ST_WRITE) act_q <= head_idx;
            if (we_live && !done) cnt_q <= cnt_q + 1'b1;
            else                  cnt_q <= '0;
        end
    end

    always_comb begin
        arr_we       = we_live;
        arr_rd       = (state_q == ST_RD_ARRAY);
        rsp_valid    = (state_q == ST_RD_RETURN) || (state_q == ST_RD_HIT);
        rsp_from_buf = (state_q == ST_RD_HIT);
        retire_en    = done;
        act_idx      = act_q;
    end
endmodule

// File: rtl/nvm_wbuf.sv
module nvm_wbuf #(
    parameter int DEPTH   = 4,
    parameter int AW      = 8,
    parameter int DW      = 16,
    parameter int WR_LAT  = 8,
    parameter int HI_MARK = 3,
    parameter int LO_MARK = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_valid,
    output logic          wr_ready,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_valid,
    output logic          rd_ready,
    input  logic [AW-1:0] rd_addr,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_data,
    output logic          arr_we,
    output logic          arr_rd,
    output logic [AW-1:0] arr_addr,
    output logic [DW-1:0] arr_wdata,
    input  logic [DW-1:0] arr_rdata
);
    localparam int IW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic          wr_fire, wr_hit, rd_hit, rd_fire;
    logic [IW-1:0] wr_hit_idx, head_idx, act_idx;
    logic [DW-1:0] rd_hit_data, sel_data;
    logic [AW-1:0] sel_addr;
    logic          any_valid, retire_en, rsp_from_buf;
    logic [CW-1:0] occupancy;
    logic [AW-1:0] rd_addr_q;
    logic [DW-1:0] hit_data_q;

    assign wr_fire = wr_valid && wr_ready;

    wbuf_store #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) i_store (
        .clk(clk), .rst_n(rst_n),
        .wr_fire(wr_fire), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_ready(wr_ready), .wr_hit(wr_hit), .wr_hit_idx(wr_hit_idx),
        .rd_addr(rd_addr), .rd_hit(rd_hit), .rd_hit_data(rd_hit_data),
        .retire_en(retire_en), .retire_idx(act_idx),
        .sel_idx(act_idx), .sel_addr(sel_addr), .sel_data(sel_data),
        .head_idx(head_idx), .any_valid(any_valid), .occupancy(occupancy)
    );

    wbuf_ctrl #(.DEPTH(DEPTH), .WR_LAT(WR_LAT), .HI_MARK(HI_MARK), .LO_MARK(LO_MARK)) i_ctrl (
        .clk(clk), .rst_n(rst_n),
        .rd_valid(rd_valid), .rd_hit(rd_hit),
        .wr_fire(wr_fire), .wr_hit(wr_hit), .wr_hit_idx(wr_hit_idx),
        .occupancy(occupancy), .any_valid(any_valid), .head_idx(head_idx),
        .rd_ready(rd_ready), .rd_fire(rd_fire),
        .arr_we(arr_we), .arr_rd(arr_rd),
        .rsp_valid(rsp_valid), .rsp_from_buf(rsp_from_buf),
        .retire_en(retire_en), .act_idx(act_idx)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_addr_q  <= '0;
            hit_data_q <= '0;
        end else if (rd_fire) begin
            rd_addr_q  <= rd_addr;
            hit_data_q <= rd_hit_data;
        end
    end

    assign arr_addr  = arr_rd ? rd_addr_q : sel_addr;
    assign arr_wdata = sel_data;
    assign rsp_data  = rsp_from_buf ? hit_data_q : arr_rdata;

    // R7
    single_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(arr_we && arr_rd));

    // R2
    wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_we && $past(arr_we)) |-> ($stable(arr_addr) && $stable(arr_wdata)));

    // R3
    rd_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arr_rd |=> rsp_valid);

    // R8
    drain_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (occupancy >= CW'(HI_MARK)) |=> !rd_ready);
endmodule

// File: tb/test_nvm_wbuf.sv
`timescale 1ns/1ps
module test_nvm_wbuf;
    localparam int AW = 8;
    localparam int DW = 16;
    localparam int WR_LAT = 8;
    localparam int NVEC = 12;
    // {is_write, addr, data}
    localparam logic [24:0] VEC [NVEC] = '{
        {1'b1, 8'h40, 16'h1111}, {1'b0, 8'h40, 16'h0000},
        {1'b1, 8'h41, 16'h2222}, {1'b1, 8'h40, 16'h3333},
        {1'b0, 8'h40, 16'h0000}, {1'b0, 8'h41, 16'h0000},
        {1'b0, 8'h55, 16'h0000}, {1'b1, 8'h55, 16'h4444},
        {1'b0, 8'h55, 16'h0000}, {1'b0, 8'h66, 16'h0000},
        {1'b1, 8'h41, 16'h5555}, {1'b0, 8'h41, 16'h0000}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_valid = 1'b0, rd_valid = 1'b0;
    logic [AW-1:0] wr_addr = '0, rd_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic wr_ready, rd_ready, rsp_valid, arr_we, arr_rd;
    logic [DW-1:0] rsp_data, arr_wdata;
    logic [DW-1:0] arr_rdata = '0;
    logic [AW-1:0] arr_addr;

    logic [DW-1:0] mem [256];
    logic [DW-1:0] exp_mem [256];
    int clash = 0, rd_cnt = 0, commits = 0, run = 0;
    logic [AW-1:0] l_addr = '0;
    logic [DW-1:0] l_data = '0;
    int total = 0, failed = 0;

    always #5 clk = ~clk;

    nvm_wbuf i_nvm_wbuf (
        .clk(clk), .rst_n(rst_n),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .arr_we(arr_we), .arr_rd(arr_rd), .arr_addr(arr_addr),
        .arr_wdata(arr_wdata), .arr_rdata(arr_rdata)
    );

    // array model: a write lands after WR_LAT unbroken, unchanged cycles
    always @(posedge clk) begin
        int run_n;
        if (arr_we && arr_rd) clash++;
        if (arr_rd) begin
            arr_rdata <= mem[arr_addr];
            rd_cnt++;
        end
        if (arr_we) begin
            if (run > 0 && arr_addr == l_addr && arr_wdata == l_data) run_n = run + 1;
            else run_n = 1;
            l_addr = arr_addr;
            l_data = arr_wdata;
            if (run_n == WR_LAT) begin
                mem[arr_addr] = arr_wdata;
                commits++;
                run = 0;
            end else begin
                run = run_n;
            end
        end else begin
            run = 0;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            failed++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        wr_valid = 1'b1; wr_addr = a; wr_data = d;
        #1;
        while (!wr_ready) begin @(negedge clk); #1; end
        @(negedge clk);
        wr_valid = 1'b0;
        exp_mem[a] = d;
    endtask

    task automatic do_read(input logic [AW-1:0] a, output logic [DW-1:0] d,
                           output int lat, output int reads);
        int r0;
        @(negedge clk);
        rd_valid = 1'b1; rd_addr = a;
        #1;
        while (!rd_ready) begin @(negedge clk); #1; end
        r0 = rd_cnt;
        @(negedge clk);
        rd_valid = 1'b0;
        lat = 1;
        while (!rsp_valid && lat < 10) begin @(negedge clk); lat++; end
        d = rsp_data;
        reads = rd_cnt - r0;
    endtask

    task automatic wait_idle();
        repeat (80) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failed++; total++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end

    initial begin
        logic [DW-1:0] d;
        int lat, reads, c0;
        for (int i = 0; i < 256; i++) begin
            mem[i] = {i[7:0], ~i[7:0]};
            exp_mem[i] = {i[7:0], ~i[7:0]};
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(wr_ready && rd_ready, "R1 ready", {wr_ready, rd_ready}, 3);
        check(!arr_we && !arr_rd && !rsp_valid, "R1 idle", {arr_we, arr_rd, rsp_valid}, 0);

        // vector walk; reads compare with the latest written value (R3)
        for (int v = 0; v < NVEC; v++) begin
            if (VEC[v][24]) begin
                do_write(VEC[v][23:16], VEC[v][15:0]);
            end else begin
                do_read(VEC[v][23:16], d, lat, reads);
                check(d == exp_mem[VEC[v][23:16]], "R3 vector read", d, exp_mem[VEC[v][23:16]]);
            end
        end
        wait_idle();

        // R3 miss timing
        do_read(8'h22, d, lat, reads);
        check(lat == 2 && reads == 1, "R3 miss timing", lat * 16 + reads, 2 * 16 + 1);
        check(d == 16'h22DD, "R3 miss data", d, 16'h22DD);

        // R4 hit timing and data, array untouched
        do_write(8'h70, 16'hAAAA);
        do_read(8'h70, d, lat, reads);
        check(lat == 1 && reads == 0, "R4 hit timing", lat * 16 + reads, 1 * 16);
        check(d == 16'hAAAA, "R4 hit data", d, 16'hAAAA);
        wait_idle();

        // R5 merge: one array write with the latest data
        c0 = commits;
        do_write(8'h30, 16'hB001);
        do_write(8'h30, 16'hB002);
        wait_idle();
        check(commits - c0 == 1, "R5 single write", commits - c0, 1);
        check(mem[8'h30] == 16'hB002, "R5 latest data", mem[8'h30], 16'hB002);

        // R6 read pre-empts a running write
        c0 = commits;
        do_write(8'h10, 16'hC0DE);
        while (run < 3) @(negedge clk);
        @(negedge clk);
        rd_valid = 1'b1; rd_addr = 8'h20;
        #1;
        check(rd_ready == 1'b1, "R6 read taken at once", rd_ready, 1);
        @(negedge clk);
        rd_valid = 1'b0;
        check(run == 0 && commits == c0, "R6 write dropped", run, 0);
        @(negedge clk);
        check(rsp_valid && rsp_data == 16'h20DF, "R6 read data", rsp_data, 16'h20DF);
        wait_idle();
        check(commits - c0 == 1 && mem[8'h10] == 16'hC0DE, "R6 write retried", mem[8'h10], 16'hC0DE);

        // R8 drain mode
        c0 = commits;
        do_write(8'h80, 16'h0080);
        do_write(8'h81, 16'h0081);
        do_write(8'h82, 16'h0082);
        @(negedge clk);
        check(rd_ready == 1'b0, "R8 reads blocked", rd_ready, 0);
        for (int k = 0; k < 200 && !rd_ready; k++) @(negedge clk);
        check(commits - c0 == 3, "R8 drained to empty", commits - c0, 3);
        wait_idle();

        // R9 full buffer
        do_write(8'h90, 16'h0090);
        do_write(8'h91, 16'h0091);
        do_write(8'h92, 16'h0092);
        do_write(8'h93, 16'h0093);
        wr_addr = 8'h94;
        #1;
        check(wr_ready == 1'b0, "R9 full refuses new line", wr_ready, 0);
        wr_addr = 8'h92;
        #1;
        check(wr_ready == 1'b1, "R9 full takes matching line", wr_ready, 1);
        do_write(8'h94, 16'h0094);
        wait_idle();

        // R2 every write landed; R7 port never shared
        c0 = 0;
        for (int i = 0; i < 256; i++) if (mem[i] != exp_mem[i]) c0++;
        check(c0 == 0, "R2 array contents", c0, 0);
        check(clash == 0, "R7 port clash", clash, 0);

        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end
endmodule